// File: doc/BRIEF.md
# Deblocking Edge Smoother

This block removes blocking artefacts along one boundary between two 8x8 pixel blocks. Four pixels that lie on a line across the boundary go in together: two before it and two after it. The block computes a signed correction from them, shapes that correction with a configurable strength, and returns new values for the two pixels that touch the boundary. The two outer pixels only feed the estimate and are never rewritten. Small steps across the boundary are smoothed away. Steps large enough to be real picture detail get a correction that shrinks to zero.

A fetch engine outside the block walks the eight positions of an edge and streams them in, one quad per clock cycle. For a vertical boundary it takes pixels from neighbouring columns. For a horizontal boundary it takes them from neighbouring rows. The kernel is the same in both cases. The strength is written through a small configuration port. The block keeps twice that value in a register, so the datapath never has to multiply. Each result comes out with its position tag two cycles after its quad went in.

Top module: `edge_smoother`

## Requirements
- R1: `in_quad` carries a outer-before in bits 7:0, b inner-before in bits 15:8, c inner-after in bits 23:16 and d outer-after in bits 31:24. The raw response is R = floor((a - d + 3*(c - b) + 4) / 8), computed as an arithmetic shift of an exact signed sum.
- R2: The applied correction has the sign of R and magnitude min(|R|, max(2L - |R|, 0)), where L is the configured strength.
- R3: `out_near` = b + correction and `out_far` = c - correction. Each is clamped to 0..255.
- R4: A quad accepted in cycle t yields `out_valid` with its own `out_pos` two cycles later. Back-to-back quads are accepted with no gaps, and `out_valid` is low whenever no quad was accepted two cycles earlier.
- R5: A write with `cfg_we` high stores 2 * `cfg_limit`. The stored value holds until the next write and applies to every quad accepted after the write.
- R6: With L = 0 the outputs equal b and c unchanged.
- R7: A synchronous reset drops every quad in flight, so `out_valid` is low in the cycle after reset. The stored strength survives reset.
- R8: When |R| >= 2L the pixels pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Strength write strobe |
| cfg_limit | input | 7 | Strength L, 0..127 |
| in_valid | input | 1 | Quad present this cycle |
| in_pos | input | 3 | Position of the quad along the edge |
| in_quad | input | 32 | Four packed pixels, layout per R1 |
| out_valid | output | 1 | Result present |
| out_pos | output | 3 | Position tag of the result |
| out_near | output | 8 | Updated inner-before pixel |
| out_far | output | 8 | Updated inner-after pixel |

## Verification
A corrupted valid bit in either stage shows up at the ports within two cycles, as a missing or extra `out_valid` next to the expected stream. A wrong registered response or inner pixel affects only the one position that carries it. That position's `out_near`/`out_far` differ from the reference exactly two cycles after entry. A stale or wrongly scaled strength register shows on the first quad after a write whose |R| falls between the old and new thresholds. The directed vectors place |R| on both sides of 2L for this reason.

// File: rtl/edge_smooth_pkg.sv
`timescale 1ns/1ps
package edge_smooth_pkg;
  // default widths shared by the stages
  localparam int unsigned PIX_W_DEF = 8;
  localparam int unsigned LIM_W_DEF = 7;
  localparam int unsigned POS_W_DEF = 3;
  // pixels per quad across the edge
  localparam int unsigned LANES     = 4;
  // lane roles inside a quad
  localparam int unsigned LANE_OUT_A = 0;
  localparam int unsigned LANE_IN_B  = 1;
  localparam int unsigned LANE_IN_C  = 2;
  localparam int unsigned LANE_OUT_D = 3;
endpackage

// File: rtl/edge_resp.sv
`timescale 1ns/1ps
// Stage 1: unpack quad, compute raw signed response, register it.
module edge_resp
  import edge_smooth_pkg::*;
#(
  parameter int unsigned PIX_W = PIX_W_DEF,
  parameter int unsigned POS_W = POS_W_DEF
)(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [POS_W-1:0]        in_pos,
  input  logic [LANES*PIX_W-1:0]  in_quad,
  output logic                    s1_valid,
  output logic [POS_W-1:0]        s1_pos,
  output logic [PIX_W-1:0]        s1_near,
  output logic [PIX_W-1:0]        s1_far,
  output logic signed [PIX_W:0]   s1_resp
);
  localparam int unsigned RESP_W = PIX_W + 1;
  localparam int unsigned SUM_W  = PIX_W + 4;

  logic [PIX_W-1:0] lane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_unpack
    assign lane[g] = in_quad[g*PIX_W +: PIX_W];
  end

  logic signed [SUM_W-1:0] outer_d, inner_d, total;
  logic signed [RESP_W-1:0] resp_d;

  always_comb begin
    outer_d = $signed({4'b0000, lane[LANE_OUT_A]}) - $signed({4'b0000, lane[LANE_OUT_D]});
    inner_d = $signed({4'b0000, lane[LANE_IN_C]})  - $signed({4'b0000, lane[LANE_IN_B]});
    total   = outer_d + inner_d + (inner_d <<< 1) + SUM_W'(4);
    resp_d  = RESP_W'(total >>> 3);
  end

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_pos  <= in_pos;
      s1_near <= lane[LANE_IN_B];
      s1_far  <= lane[LANE_IN_C];
      s1_resp <= resp_d;
    end
  end
endmodule

// File: rtl/resp_limit.sv
`timescale 1ns/1ps
// Combinational ramp limiter: sign(R) * min(|R|, max(2L-|R|, 0)).
module resp_limit
  import edge_smooth_pkg::*;
#(
  parameter int unsigned PIX_W = PIX_W_DEF
)(
  input  logic signed [PIX_W:0] resp,
  input  logic [PIX_W-1:0]      dbl_lim,
  output logic signed [PIX_W:0] lim
);
  localparam int unsigned RESP_W = PIX_W + 1;

  logic              neg;
  logic [RESP_W-1:0] mag, ceiling, room, kept;

  always_comb begin
    neg     = resp[RESP_W-1];
    mag     = neg ? RESP_W'(-resp) : RESP_W'(resp);
    ceiling = {1'b0, dbl_lim};
    room    = (ceiling > mag) ? (ceiling - mag) : '0;
    kept    = (mag < room) ? mag : room;
    lim     = neg ? -$signed(kept) : $signed(kept);
  end
endmodule

// File: rtl/edge_apply.sv
`timescale 1ns/1ps
// Stage 2: limit the response, apply to inner pixels, clamp, register.
module edge_apply
  import edge_smooth_pkg::*;
#(
  parameter int unsigned PIX_W = PIX_W_DEF,
  parameter int unsigned POS_W = POS_W_DEF
)(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  s1_valid,
  input  logic [POS_W-1:0]      s1_pos,
  input  logic [PIX_W-1:0]      s1_near,
  input  logic [PIX_W-1:0]      s1_far,
  input  logic signed [PIX_W:0] s1_resp,
  input  logic [PIX_W-1:0]      dbl_lim,
  output logic                  out_valid,
  output logic [POS_W-1:0]      out_pos,
  output logic [PIX_W-1:0]      out_near,
  output logic [PIX_W-1:0]      out_far
);
  localparam int unsigned RESP_W = PIX_W + 1;
  localparam int unsigned EXT_W  = PIX_W + 2;

  logic signed [RESP_W-1:0] lim;

  resp_limit #(.PIX_W(PIX_W)) u_limit (
    .resp    (s1_resp),
    .dbl_lim (dbl_lim),
    .lim     (lim)
  );

  logic signed [EXT_W-1:0] lim_x, near_x, far_x;
  logic [PIX_W-1:0]        near_c, far_c;

  always_comb begin
    lim_x  = EXT_W'(lim);
    near_x = $signed({2'b00, s1_near}) + lim_x;
    far_x  = $signed({2'b00, s1_far})  - lim_x;
    if (near_x[EXT_W-1])                near_c = '0;
    else if (|near_x[EXT_W-2:PIX_W])    near_c = '1;
    else                                near_c = near_x[PIX_W-1:0];
    if (far_x[EXT_W-1])                 far_c = '0;
    else if (|far_x[EXT_W-2:PIX_W])     far_c = '1;
    else                                far_c = far_x[PIX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= s1_valid;
  end

  always_ff @(posedge clk) begin
    if (s1_valid) begin
      out_pos  <= s1_pos;
      out_near <= near_c;
      out_far  <= far_c;
    end
  end

  // independent magnitudes for the checks below
  logic [RESP_W-1:0] r_mag, l_mag;
  always_comb begin
    r_mag = s1_resp[RESP_W-1] ? RESP_W'(-s1_resp) : RESP_W'(s1_resp);
    l_mag = lim[RESP_W-1]     ? RESP_W'(-lim)     : RESP_W'(lim);
  end

  // R2
  lim_bound_chk: assert property (@(posedge clk) disable iff (rst)
    s1_valid |-> (l_mag <= r_mag) && ((lim == '0) || (r_mag + l_mag <= {1'b0, dbl_lim})));

  // R2
  lim_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && lim != '0) |-> (lim[RESP_W-1] == s1_resp[RESP_W-1]));

  // R8
  strong_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && r_mag >= RESP_W'(dbl_lim)) |-> (lim == '0));

  // R6
  zero_ident_chk: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && dbl_lim == '0) |=> (out_near == $past(s1_near)) && (out_far == $past(s1_far)));
endmodule

// File: rtl/edge_smoother.sv
`timescale 1ns/1ps
// Top: strength register plus two-stage edge smoothing pipeline.
module edge_smoother
  import edge_smooth_pkg::*;
#(
  parameter int unsigned PIX_W = PIX_W_DEF,
  parameter int unsigned LIM_W = LIM_W_DEF,
  parameter int unsigned POS_W = POS_W_DEF
)(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  logic [LIM_W-1:0]       cfg_limit,
  input  logic                   in_valid,
  input  logic [POS_W-1:0]       in_pos,
  input  logic [LANES*PIX_W-1:0] in_quad,
  output logic                   out_valid,
  output logic [POS_W-1:0]       out_pos,
  output logic [PIX_W-1:0]       out_near,
  output logic [PIX_W-1:0]       out_far
);
  localparam int unsigned RESP_W = PIX_W + 1;

  // doubled strength, kept across reset
  logic [PIX_W-1:0] dbl_lim;
  always_ff @(posedge clk) begin
    if (cfg_we) dbl_lim <= PIX_W'({cfg_limit, 1'b0});
  end

  logic                     s1_valid;
  logic [POS_W-1:0]         s1_pos;
  logic [PIX_W-1:0]         s1_near, s1_far;
  logic signed [RESP_W-1:0] s1_resp;

  edge_resp #(.PIX_W(PIX_W), .POS_W(POS_W)) u_resp (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_pos   (in_pos),
    .in_quad  (in_quad),
    .s1_valid (s1_valid),
    .s1_pos   (s1_pos),
    .s1_near  (s1_near),
    .s1_far   (s1_far),
    .s1_resp  (s1_resp)
  );

  edge_apply #(.PIX_W(PIX_W), .POS_W(POS_W)) u_apply (
    .clk       (clk),
    .rst       (rst),
    .s1_valid  (s1_valid),
    .s1_pos    (s1_pos),
    .s1_near   (s1_near),
    .s1_far    (s1_far),
    .s1_resp   (s1_resp),
    .dbl_lim   (dbl_lim),
    .out_valid (out_valid),
    .out_pos   (out_pos),
    .out_near  (out_near),
    .out_far   (out_far)
  );

  // R4
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));

  // R4
  pos_align_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_pos == $past(in_pos, 2)));

  // R7
  rst_flush_chk: assert property (@(posedge clk)
    rst |=> !out_valid);

  // R5
  lim_hold_chk: assert property (@(posedge clk)
    !cfg_we |=> $stable(dbl_lim));
endmodule

// File: tb/sim_edge_smoother.sv
`timescale 1ns/1ps
module sim_edge_smoother;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_limit = '0;
  logic        in_valid = 1'b0;
  logic [2:0]  in_pos = '0;
  logic [31:0] in_quad = '0;
  logic        out_valid;
  logic [2:0]  out_pos;
  logic [7:0]  out_near, out_far;

  edge_smoother u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_limit(cfg_limit),
    .in_valid(in_valid), .in_pos(in_pos), .in_quad(in_quad),
    .out_valid(out_valid), .out_pos(out_pos), .out_near(out_near), .out_far(out_far)
  );

  always #2.5 clk = ~clk;

  int    compared = 0;
  int    mismatched = 0;
  bit    done = 1'b0;
  int    cur_dbl = 0;
  bit    pv [2];
  int    ppos [2];
  int    pn [2];
  int    pf [2];
  string ptag [2];

  // behavioural reference for one quad (R1, R2, R3)
  function automatic void ref_quad(input logic [31:0] q, input int dbl, output int n, output int f);
    int a, b, c, d, s, r, mag, room, m, lim;
    a = int'(q[7:0]); b = int'(q[15:8]); c = int'(q[23:16]); d = int'(q[31:24]);
    s = a - d + 3 * (c - b) + 4;
    r = s >>> 3;
    mag = (r < 0) ? -r : r;
    room = dbl - mag;
    if (room < 0) room = 0;
    m = (mag < room) ? mag : room;
    lim = (r < 0) ? -m : m;
    n = b + lim; if (n < 0) n = 0; if (n > 255) n = 255;
    f = c - lim; if (f < 0) f = 0; if (f > 255) f = 255;
  endfunction

  task automatic compare();
    compared++;
    if (out_valid !== pv[1]) begin
      mismatched++;
      $display("FAIL %s: out_valid=%0b expected %0b", ptag[1], out_valid, pv[1]);
    end else if (pv[1]) begin
      compared++;
      if (out_pos !== 3'(ppos[1]) || out_near !== 8'(pn[1]) || out_far !== 8'(pf[1])) begin
        mismatched++;
        $display("FAIL %s: pos/near/far=%0d/%0d/%0d expected %0d/%0d/%0d",
                 ptag[1], out_pos, out_near, out_far, ppos[1], pn[1], pf[1]);
      end
    end
  endtask

  task automatic shift();
    pv[1] = pv[0]; ppos[1] = ppos[0]; pn[1] = pn[0]; pf[1] = pf[0]; ptag[1] = ptag[0];
  endtask

  task automatic tick(input bit v, input int pos, input logic [31:0] q, input string tag);
    int n, f;
    @(negedge clk);
    compare();
    shift();
    in_valid = v; in_pos = 3'(pos); in_quad = q;
    pv[0] = v; ppos[0] = pos; ptag[0] = v ? tag : "R4";
    if (v) begin
      ref_quad(q, cur_dbl, n, f);
      pn[0] = n; pf[0] = f;
    end
  endtask

  task automatic idle(input int cycles, input string tag);
    for (int i = 0; i < cycles; i++) tick(1'b0, 0, 32'h0, tag);
  endtask

  // R5: write strength with the pipe drained
  task automatic set_limit(input int l);
    idle(2, "R5");
    @(negedge clk);
    compare(); shift();
    in_valid = 1'b0; pv[0] = 1'b0; ptag[0] = "R5";
    cfg_we = 1'b1; cfg_limit = 7'(l); cur_dbl = 2 * l;
    @(negedge clk);
    compare(); shift();
    pv[0] = 1'b0; ptag[0] = "R5";
    cfg_we = 1'b0;
  endtask

  // R7: reset in mid stream
  task automatic pulse_reset();
    @(negedge clk);
    compare(); shift();
    rst = 1'b1; in_valid = 1'b0;
    pv[0] = 1'b0; pv[1] = 1'b0; ptag[0] = "R7"; ptag[1] = "R7";
    @(negedge clk);
    rst = 1'b0;
    pv[0] = 1'b0; pv[1] = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  function automatic logic [31:0] quad(input int a, input int b, input int c, input int d);
    return {8'(d), 8'(c), 8'(b), 8'(a)};
  endfunction

  initial begin
    pv[0] = 0; pv[1] = 0; ptag[0] = "R7"; ptag[1] = "R7";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R7: reset state, nothing valid
    idle(2, "R7");

    // R6: zero strength leaves pixels untouched
    set_limit(0);
    for (int i = 0; i < 16; i++) tick(1'b1, i % 8, $urandom, "R6");

    // R2: strongest setting, response 128 clipped to 126
    set_limit(127);
    tick(1'b1, 0, quad(255, 0, 255, 0), "R2");
    tick(1'b1, 1, quad(0, 255, 0, 255), "R2");
    // R1: full edge streamed back to back
    for (int i = 0; i < 8; i++) tick(1'b1, i, $urandom, "R1");
    // R4: bubbles between positions
    for (int i = 0; i < 8; i++) begin
      tick(1'b1, 7 - i, $urandom, "R4");
      if (i % 3 == 0) tick(1'b0, 0, 32'h0, "R4");
    end

    // R3: clamping at both ends, and R1 floor rounding of -1
    set_limit(40);
    tick(1'b1, 2, quad(255, 250, 255, 0), "R3");
    tick(1'b1, 3, quad(0, 5, 0, 255), "R3");
    tick(1'b1, 4, quad(0, 100, 100, 5), "R1");

    // R8 / R2: threshold 6
    set_limit(3);
    tick(1'b1, 5, quad(0, 0, 200, 200), "R8");
    tick(1'b1, 6, quad(0, 100, 110, 0), "R2");
    tick(1'b1, 7, quad(3, 100, 100, 0), "R2");
    tick(1'b1, 0, quad(0, 10, 12, 0), "R8");

    // R5: several strengths, each applied to a stream
    for (int k = 0; k < 4; k++) begin
      set_limit((k * 37 + 5) % 128);
      for (int i = 0; i < 24; i++) tick(1'b1, i % 8, $urandom, "R5");
    end

    // R7: reset drops in-flight data and keeps the strength
    set_limit(9);
    tick(1'b1, 1, $urandom, "R7");
    tick(1'b1, 2, $urandom, "R7");
    pulse_reset();
    tick(1'b0, 0, 32'h0, "R7");
    tick(1'b1, 3, quad(0, 50, 60, 0), "R7");
    tick(1'b1, 4, $urandom, "R7");
    idle(4, "R4");

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL R4: watchdog expired, actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule